// File: doc/BRIEF.md
# SIMD Lane Transpose Permute Unit

This unit rearranges the lanes of two source vectors into one destination vector for a vector execution pipeline. Both operands are up to 128 bits wide and carry lanes of 8, 16, 32 or 64 bits. For every pair of adjacent result lanes, the lower lane comes from the first operand and the upper lane comes from the second operand. Both lanes are taken from the same source lane position. A mode bit picks that position. Mode 0 takes the even-numbered source lanes and mode 1 takes the odd-numbered ones. Running both modes over the same two vectors gives the transposed 2x2 lane blocks.

The controls (element size code, width bit and mode bit) come from one of two places. They can be driven on dedicated pins, or they can be extracted from a 32-bit instruction word by a small front end that also recovers the three register indices. A select pin chooses between the two. The result registers one cycle after the request in every case. One size/width combination is reserved; a request with that encoding produces no result and raises an undefined-encoding flag instead.

Top module: `trn_permute_unit`

## Requirements
- R1: The element size in bits is 8 shifted left by the 2-bit size code (00=8, 01=16, 10=32, 11=64). The lane count is the vector width divided by that size.
- R2: Let pair index p run from 0 to lanes/2-1. Result lane 2p equals first-operand lane 2p+mode, and result lane 2p+1 equals second-operand lane 2p+mode. Lane k occupies bits [k*esize +: esize].
- R3: Mode 0 selects even source lanes and mode 1 selects odd source lanes. Applying both modes to the same operands yields the 2x2 transposed lane pairs.
- R4: With width bit 0 the vector is 64 bits wide. Bits 127:64 of both operands are ignored and bits 127:64 of the result are zero.
- R5: Size code 11 with width bit 0 is reserved. Such a request sets out_undef and leaves out_valid low one cycle later. The result and index outputs keep their previous values.
- R6: out_undef is asserted only in the cycle after a valid request carrying the reserved combination. All other seven size/width combinations leave it low.
- R7: The latency is fixed at one cycle and does not depend on data. out_valid is high exactly in the cycle after a non-reserved request. Without a request, both out_valid and out_undef are low.
- R8: A clock edge with rst_n low clears out_valid, out_undef, the result and the index outputs, even when a request is present in that cycle.
- R9: With ctl_src=1 the controls come from in_word. The width bit is bit 30, the size code is bits 23:22 and the mode is bit 14. The second source index is bits 20:16, the first source index is bits 9:5 and the destination index is bits 4:0. These indices appear registered on out_src_b, out_src_a and out_dst.
- R10: With ctl_src=0 the controls come from in_wide, in_size and in_mode, and in_word has no effect. The registered index outputs are then zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| ctl_src | input | 1 | 1: controls from in_word, 0: from pins |
| in_word | input | 32 | Instruction word |
| in_wide | input | 1 | Width bit: 1 = 128-bit, 0 = 64-bit |
| in_size | input | 2 | Element size code |
| in_mode | input | 1 | 0 = even lanes, 1 = odd lanes |
| op_a | input | 128 | First operand |
| op_b | input | 128 | Second operand |
| out_valid | output | 1 | Result valid strobe |
| out_undef | output | 1 | Reserved encoding flag |
| out_result | output | 128 | Registered result |
| out_dst | output | 5 | Registered destination index |
| out_src_a | output | 5 | Registered first source index |
| out_src_b | output | 5 | Registered second source index |

## Verification
Two pairs of functions can fall in the same cycle. The first is reset and a request; the second is the reserved-encoding flag and the hold of the previous result. The bench raises in_valid with a legal request while rst_n is low, and expects every output cleared on the next cycle. It then issues a reserved request directly after a good one, and expects out_undef high, out_valid low, and the earlier result and indices unchanged. Every table row is also compared, one cycle after issue, against a lane-by-lane model built from the mapping rule.

// File: rtl/trn_pkg.sv
// Package: shared types and constants for the lane transpose permute unit.
// Assumes a 32-bit instruction word and 5-bit register indices.
package trn_pkg;

    localparam int IDX_W     = 5;
    localparam int WORD_W    = 32;
    localparam int SIZE_W    = 2;
    localparam int NUM_SIZES = 4;
    localparam int MIN_ESIZE = 8;

    // Field positions in the instruction word.
    localparam int POS_WIDE  = 30;
    localparam int POS_SIZE  = 22;
    localparam int POS_SRCB  = 16;
    localparam int POS_MODE  = 14;
    localparam int POS_SRCA  = 5;
    localparam int POS_DST   = 0;

    // Constant opcode bits that an upstream decoder has already matched.
    localparam logic [WORD_W-1:0] FIXED_MASK = 32'hBF20_BC00;
    localparam logic [WORD_W-1:0] FIXED_VAL  = 32'h0E00_2800;

    typedef struct packed {
        logic              wide;
        logic [SIZE_W-1:0] size;
        logic              mode;
    } trn_ctl_t;

    typedef struct packed {
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
    } trn_idx_t;

    // Reserved encoding: 64-bit lanes in a 64-bit vector.
    function automatic logic is_reserved(input trn_ctl_t c);
        return (c.size == 2'b11) && !c.wide;
    endfunction

endpackage

// File: rtl/trn_word_decode.sv
// Module: trn_word_decode
// Extracts width, size, mode and the three register indices from a
// 32-bit instruction word. Assumes the constant opcode bits already
// matched upstream; a checker guards that assumption.
module trn_word_decode
    import trn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output trn_ctl_t          ctl,
    output trn_idx_t          idx
);

    // Slice the control fields out of the word.
    always_comb begin
        ctl.wide  = word[POS_WIDE];
        ctl.size  = word[POS_SIZE +: SIZE_W];
        ctl.mode  = word[POS_MODE];
        idx.dst   = word[POS_DST  +: IDX_W];
        idx.src_a = word[POS_SRCA +: IDX_W];
        idx.src_b = word[POS_SRCB +: IDX_W];
    end

    // R9: only words carrying this opcode pattern are routed here.
    a_r9_opcode_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ((word & FIXED_MASK) == FIXED_VAL));

endmodule

// File: rtl/trn_lane_shuffle.sv
// Module: trn_lane_shuffle
// Fixed-element-size interleave over a full VEC_W vector: result lane 2p
// takes lane 2p+mode of src_a, result lane 2p+1 takes lane 2p+mode of src_b.
// Assumes VEC_W is a multiple of 2*ESIZE.
module trn_lane_shuffle #(
    parameter int VEC_W = 128,
    parameter int ESIZE = 8
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic             mode,
    output logic [VEC_W-1:0] dst
);

    localparam int LANES = VEC_W / ESIZE;
    localparam int PAIRS = LANES / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        localparam int EVN = 2 * p;
        localparam int ODD = 2 * p + 1;
        // Pick the even or odd lane of each source for this pair.
        always_comb begin
            dst[EVN*ESIZE +: ESIZE] = mode ? src_a[ODD*ESIZE +: ESIZE]
                                           : src_a[EVN*ESIZE +: ESIZE];
            dst[ODD*ESIZE +: ESIZE] = mode ? src_b[ODD*ESIZE +: ESIZE]
                                           : src_b[EVN*ESIZE +: ESIZE];
        end
    end

endmodule

// File: rtl/trn_lane_permute.sv
// Module: trn_lane_permute
// Builds one shuffle per element size and selects by size code; in
// 64-bit width the upper half is forced to zero. The lower half of any
// shuffle depends only on the lower half of the sources, so no separate
// narrow path is needed.
module trn_lane_permute
    import trn_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  trn_ctl_t         ctl,
    output logic [VEC_W-1:0] dst
);

    localparam int HALF_W = VEC_W / 2;

    logic [VEC_W-1:0] cand [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        trn_lane_shuffle #(
            .VEC_W (VEC_W),
            .ESIZE (MIN_ESIZE << s)
        ) u_shuf (
            .src_a (src_a),
            .src_b (src_b),
            .mode  (ctl.mode),
            .dst   (cand[s])
        );
    end

    // Select by element size and clear the upper half when narrow.
    always_comb begin
        dst = cand[ctl.size];
        if (!ctl.wide) begin
            dst[VEC_W-1:HALF_W] = '0;
        end
    end

endmodule

// File: rtl/trn_out_stage.sv
// Module: trn_out_stage
// One-cycle output register. It latches the result and indices only for
// legal requests, and flags reserved requests without touching the data.
// Reset is synchronous and active low.
module trn_out_stage
    import trn_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             reserved,
    input  logic [VEC_W-1:0] result_nxt,
    input  trn_idx_t         idx_nxt,
    output logic             out_valid,
    output logic             out_undef,
    output logic [VEC_W-1:0] result,
    output trn_idx_t         idx
);

    // Strobes: valid for legal requests, undef for reserved ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
        end else begin
            out_valid <= req && !reserved;
            out_undef <= req && reserved;
        end
    end

    // Data: capture only on a legal request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            idx    <= '0;
        end else if (req && !reserved) begin
            result <= result_nxt;
            idx    <= idx_nxt;
        end
    end

    // R7: fixed single-cycle latency for legal requests.
    a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !reserved) |=> (out_valid && !out_undef));

    // R7: no request, no strobe.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!out_valid && !out_undef));

    // R5: a reserved request is flagged and produces no result.
    a_r5_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req && reserved) |=> (out_undef && !out_valid));

    // R5: the result is held across an undefined response.
    a_r5_hold_on_undef: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> ($stable(result) && $stable(idx)));

    // R8: a reset edge clears both strobes.
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_undef));

    // R5: the two strobes never coexist.
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_undef));

endmodule

// File: rtl/trn_permute_unit.sv
// Module: trn_permute_unit (top)
// Lane transpose permute unit. It picks controls from pins or from an
// instruction word, permutes the operand lanes, and registers the result
// with a fixed one-cycle latency. The register file and any trap or
// enable checks live outside this block.
module trn_permute_unit
    import trn_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                ctl_src,
    input  logic [WORD_W-1:0]   in_word,
    input  logic                in_wide,
    input  logic [SIZE_W-1:0]   in_size,
    input  logic                in_mode,
    input  logic [VEC_W-1:0]    op_a,
    input  logic [VEC_W-1:0]    op_b,
    output logic                out_valid,
    output logic                out_undef,
    output logic [VEC_W-1:0]    out_result,
    output logic [IDX_W-1:0]    out_dst,
    output logic [IDX_W-1:0]    out_src_a,
    output logic [IDX_W-1:0]    out_src_b
);

    localparam int HALF_W = VEC_W / 2;

    trn_ctl_t   dec_ctl, sel_ctl;
    trn_idx_t   dec_idx, sel_idx, reg_idx;
    logic       sel_rsv;
    logic [VEC_W-1:0] perm;

    trn_word_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (in_valid && ctl_src),
        .word       (in_word),
        .ctl        (dec_ctl),
        .idx        (dec_idx)
    );

    // Choose the control source; the pin path carries no indices.
    always_comb begin
        if (ctl_src) begin
            sel_ctl = dec_ctl;
            sel_idx = dec_idx;
        end else begin
            sel_ctl = '{wide: in_wide, size: in_size, mode: in_mode};
            sel_idx = '0;
        end
        sel_rsv = is_reserved(sel_ctl);
    end

    trn_lane_permute #(.VEC_W(VEC_W)) u_perm (
        .src_a (op_a),
        .src_b (op_b),
        .ctl   (sel_ctl),
        .dst   (perm)
    );

    trn_out_stage #(.VEC_W(VEC_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (in_valid),
        .reserved   (sel_rsv),
        .result_nxt (perm),
        .idx_nxt    (sel_idx),
        .out_valid  (out_valid),
        .out_undef  (out_undef),
        .result     (out_result),
        .idx        (reg_idx)
    );

    // Fan the registered indices out to the ports.
    always_comb begin
        out_dst   = reg_idx.dst;
        out_src_a = reg_idx.src_a;
        out_src_b = reg_idx.src_b;
    end

    // R4: a narrow legal result has a zero upper half.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sel_ctl.wide && !sel_rsv) |=> (out_result[VEC_W-1:HALF_W] == '0));

    // R6: the flag is raised only for the reserved combination.
    a_r6_undef_only_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sel_rsv) |=> !out_undef);

    // R10: pin-sourced requests leave the indices zero.
    a_r10_pin_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctl_src && !sel_rsv) |=> (out_dst == '0 && out_src_a == '0 && out_src_b == '0));

endmodule

// File: tb/trn_permute_unit_tb.sv
module trn_permute_unit_tb_top;

    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          ctl_src;
    logic [31:0]   in_word;
    logic          in_wide;
    logic [1:0]    in_size;
    logic          in_mode;
    logic [VW-1:0] op_a, op_b;
    logic          out_valid, out_undef;
    logic [VW-1:0] out_result;
    logic [4:0]    out_dst, out_src_a, out_src_b;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    trn_permute_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctl_src(ctl_src),
        .in_word(in_word), .in_wide(in_wide), .in_size(in_size), .in_mode(in_mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_undef(out_undef),
        .out_result(out_result), .out_dst(out_dst), .out_src_a(out_src_a),
        .out_src_b(out_src_b)
    );

    typedef struct packed {
        logic [1:0] size;
        logic       wide;
        logic       mode;
        logic       src;
        logic       exp_undef;
    } row_t;

    localparam int NROWS = 16;
    localparam row_t TBL [NROWS] = '{
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, '{2'd0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0}, '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, '{2'd1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0}, '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0}, '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0}, '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1}, '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    // Lane-by-lane model from R1, R2 and R4.
    function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [1:0] size, input logic wide,
                                            input logic mode);
        logic [VW-1:0] r = '0;
        int es = 8 << size;
        int lanes = (wide ? 128 : 64) / es;
        for (int k = 0; k < lanes; k++) begin
            int s = (k / 2) * 2 + int'(mode);
            for (int j = 0; j < es; j++)
                r[k*es + j] = (k % 2 == 0) ? a[s*es + j] : b[s*es + j];
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] mkvec(input logic [7:0] base);
        logic [VW-1:0] v;
        for (int k = 0; k < 16; k++) v[k*8 +: 8] = base + 8'(k * 7);
        return v;
    endfunction

    function automatic logic [31:0] enc(input logic w, input logic [1:0] sz, input logic m,
                                        input logic [4:0] rm, input logic [4:0] rn,
                                        input logic [4:0] rd);
        return {1'b0, w, 6'b001110, sz, 1'b0, rm, 1'b0, m, 4'b1010, rn, rd};
    endfunction

    task automatic chk(input string req, input string what, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request at a negedge; outputs are sampled at the following negedge.
    task automatic issue(input logic [VW-1:0] a, input logic [VW-1:0] b, input logic src,
                         input logic w, input logic [1:0] sz, input logic m,
                         input logic [31:0] word);
        @(negedge clk);
        in_valid = 1'b1; ctl_src = src; in_word = word;
        in_wide = w; in_size = sz; in_mode = m; op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [VW-1:0] last_res;
        logic [14:0]   last_idx;
        rst_n = 1'b0; in_valid = 1'b0; ctl_src = 1'b0; in_word = '0;
        in_wide = 1'b0; in_size = '0; in_mode = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        chk("R8", "reset valid", VW'(out_valid), '0);
        chk("R8", "reset undef", VW'(out_undef), '0);
        chk("R8", "reset result", out_result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "idle valid", VW'(out_valid), '0);
        last_res = '0; last_idx = '0;

        // Table walk: R1, R2, R4, R5, R6, R9, R10.
        for (int i = 0; i < NROWS; i++) begin
            row_t t = TBL[i];
            logic [VW-1:0] a = mkvec(8'(i * 16));
            logic [VW-1:0] b = mkvec(8'(8'h80 + i * 3));
            logic [4:0] rd = 5'(i), rn = 5'(i + 7), rm = 5'(31 - i);
            logic [31:0] w = enc(t.wide, t.size, t.mode, rm, rn, rd);
            logic [14:0] eidx = t.src ? {rd, rn, rm} : 15'd0;
            if (t.src) issue(a, b, 1'b1, ~t.wide, ~t.size, ~t.mode, w);
            else       issue(a, b, 1'b0, t.wide, t.size, t.mode, enc(1'b0, 2'd3, ~t.mode, 5'd9, 5'd9, 5'd9));
            chk("R6", $sformatf("row %0d undef", i), VW'(out_undef), VW'(t.exp_undef));
            chk("R7", $sformatf("row %0d valid", i), VW'(out_valid), VW'(!t.exp_undef));
            if (t.exp_undef) begin
                chk("R5", $sformatf("row %0d held result", i), out_result, last_res);
                chk("R5", $sformatf("row %0d held idx", i), VW'({out_dst, out_src_a, out_src_b}), VW'(last_idx));
            end else begin
                last_res = model(a, b, t.size, t.wide, t.mode);
                last_idx = eidx;
                chk(t.src ? "R9" : "R10", $sformatf("row %0d result (R2 R1 R4)", i), out_result, last_res);
                chk(t.src ? "R9" : "R10", $sformatf("row %0d indices", i),
                    VW'({out_dst, out_src_a, out_src_b}), VW'(eidx));
            end
        end

        // R2: literal byte interleave, even lanes, full width.
        issue(mkvec(8'h00) & '0 | {8'h0F,8'h0E,8'h0D,8'h0C,8'h0B,8'h0A,8'h09,8'h08,
                                  8'h07,8'h06,8'h05,8'h04,8'h03,8'h02,8'h01,8'h00},
              {8'h8F,8'h8E,8'h8D,8'h8C,8'h8B,8'h8A,8'h89,8'h88,
               8'h87,8'h86,8'h85,8'h84,8'h83,8'h82,8'h81,8'h80},
              1'b0, 1'b1, 2'd0, 1'b0, '0);
        chk("R2", "byte interleave", out_result, 128'h8E0E_8C0C_8A0A_8808_8606_8404_8202_8000);

        // R3 and R4: 2x2 transpose of 32-bit lanes in a 64-bit vector, garbage above.
        issue({64'hDEAD_BEEF_DEAD_BEEF, 32'hA1A1_A1A1, 32'hA0A0_A0A0},
              {64'hFEED_FACE_FEED_FACE, 32'hB1B1_B1B1, 32'hB0B0_B0B0},
              1'b0, 1'b0, 2'd2, 1'b0, '0);
        chk("R3", "primary transpose", out_result, {64'd0, 32'hB0B0_B0B0, 32'hA0A0_A0A0});
        issue({64'hDEAD_BEEF_DEAD_BEEF, 32'hA1A1_A1A1, 32'hA0A0_A0A0},
              {64'hFEED_FACE_FEED_FACE, 32'hB1B1_B1B1, 32'hB0B0_B0B0},
              1'b0, 1'b0, 2'd2, 1'b1, '0);
        chk("R3", "secondary transpose", out_result, {64'd0, 32'hB1B1_B1B1, 32'hA1A1_A1A1});
        last_res = {64'd0, 32'hB1B1_B1B1, 32'hA1A1_A1A1};

        // R5: reserved request right after a good one holds the result.
        issue('1, '1, 1'b0, 1'b0, 2'd3, 1'b0, '0);
        chk("R5", "reserved undef", VW'(out_undef), 1);
        chk("R5", "reserved result held", out_result, last_res);
        @(negedge clk);
        chk("R7", "idle after undef", VW'({out_valid, out_undef}), '0);

        // R8: request during reset is discarded.
        rst_n = 1'b0;
        issue('1, '1, 1'b0, 1'b1, 2'd0, 1'b0, '0);
        chk("R8", "reset beats request valid", VW'(out_valid), '0);
        chk("R8", "reset beats request result", out_result, '0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule